// File: doc/BRIEF.md
# Conflict-Free Radix-4 Bank Address Generator

This block drives the operand fetch of an in-place radix-4 decimation-in-frequency FFT of N = 4^r points. Data is spread over four dual-port memory banks. Every cycle of a running stage, the block presents the four operands of one butterfly as (bank, in-bank address) pairs. No two operands of a butterfly ever share a bank, so all four can be read in the same cycle.

A linear address A is treated as r base-4 digits. The bank is the sum of the digits modulo 4, and the in-bank address is A with its lowest digit dropped. In stage p the four operands differ only in digit r-p-1, which takes the values 0 to 3. The other digits come from a butterfly counter. A shift mask that gains two ones at its top after each stage tells which counter digits sit above the inserted digit. Digits below that position pass straight through, and digits above it move up one place.

The generator runs all N/4 butterflies of a stage back to back. It then waits for an advance handshake before the next stage. After the last butterfly of the final stage it pulses a done flag and returns to idle.

Top module: `r4_bank_agen`

## Requirements
- R1: After reset, valid_o and done_o are 0 and stage_o is 0.
- R2: A start_i pulse while idle, with cfg_r_i in 1..MAX_R, gives valid_o = 1 and stage_o = 0 on the next cycle. A start_i pulse while busy is ignored. A start_i pulse with cfg_r_i = 0 or cfg_r_i > MAX_R is also ignored.
- R3: Each stage issues 4^(r-1) butterflies on consecutive cycles, one per cycle, in ascending counter order.
- R3 (operand address): Lane j (j = 0..3) carries the linear address whose digit r-p-1 equals j. The counter's digits below that position stay in place, and its digits at or above that position move up one digit.
- R4: bank = (sum of the base-4 digits of the linear address) mod 4. The four banks of a valid butterfly are pairwise distinct. Lane j occupies bank_o[2j+1:2j].
- R5: The in-bank address of lane j is the linear address shifted right by 2 (lowest digit removed). Together with the bank, it identifies the linear address uniquely. Lane j occupies addr_o[MW*j +: MW].
- R6: After a stage other than the last, valid_o drops and stage_o shows the next stage. The block holds there until adv_i is sampled high, and valid_o returns on the following cycle. adv_i outside this wait has no effect.
- R7: After the last butterfly of stage r-1, done_o is 1 for exactly one cycle and the block is idle, with valid_o = 0 and stage_o = 0.
- R8: While running, stage_o equals the current stage p, and p < r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transform when idle |
| adv_i | input | 1 | Permission to begin the next stage |
| cfg_r_i | input | RW | Number of base-4 digits r (N = 4^r) |
| valid_o | output | 1 | Operand addresses valid this cycle |
| stage_o | output | RW | Current stage index p |
| done_o | output | 1 | One-cycle pulse after the final butterfly |
| bank_o | output | 8 | Four 2-bit bank numbers, lane j at [2j+1:2j] |
| addr_o | output | 4*MW | Four in-bank addresses, lane j at [MW*j +: MW] |

## Verification
The generator is run with r = 1, 2, 3 and the largest r. The single-butterfly case separates a correct final-stage exit from an off-by-one count. The larger values expose digit insertion at every position, from the top digit down to the lowest. The advance handshake is held high, delayed by several cycles, and pulsed during running stages, which tells a real wait apart from a free-running stage sequence. Start pulses with out-of-range r and start pulses during a run check that such requests are ignored. Per-stage coverage of every linear address, and the inverse mapping from (bank, address) back to the linear address, show that the bank map is a bijection with no collisions.

// File: rtl/r4ag_pkg.sv
package r4ag_pkg;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_RUN  = 2'd1,
    AG_HOLD = 2'd2
  } ag_state_e;

  // 2-bit wrap-around sum built from a half adder on bit 0
  function automatic logic [1:0] add2_mod4(input logic [1:0] a, input logic [1:0] b);
    logic c0;
    c0 = a[0] & b[0];
    return {a[1] ^ b[1] ^ c0, a[0] ^ b[0]};
  endfunction

endpackage

// File: rtl/r4ag_ctrl.sv
module r4ag_ctrl
  import r4ag_pkg::*;
#(
  parameter int MAX_R = 5,
  parameter int RW    = 3,
  parameter int AW    = 10,
  parameter int CW    = 8,
  parameter int SW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic [RW-1:0] cfg_r_i,
  output logic          run_o,
  output logic [RW-1:0] stage_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] mask_o,
  output logic [RW-1:0] r_o,
  output logic          done_o
);

  ag_state_e     state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] mask;
  logic [RW-1:0] stage;
  logic [RW-1:0] r_q;
  logic          done_q;

  // named events for assertions
  logic          cfg_ok;
  logic          start_ok;
  logic          last_bfly;
  logic          last_stage;
  logic [SW-1:0] cnt_sh;
  logic [CW-1:0] cnt_last;

  always_comb begin
    cfg_ok     = (cfg_r_i != '0) && (cfg_r_i <= RW'(MAX_R));
    start_ok   = (state == AG_IDLE) && start_i && cfg_ok;
    cnt_sh     = SW'(2 * (MAX_R - int'(r_q)));
    cnt_last   = {CW{1'b1}} >> cnt_sh;
    last_bfly  = (state == AG_RUN) && (cnt == cnt_last);
    last_stage = (stage == r_q - RW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= AG_IDLE;
      cnt    <= '0;
      mask   <= '0;
      stage  <= '0;
      r_q    <= RW'(1);
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        AG_IDLE: begin
          if (start_ok) begin
            state <= AG_RUN;
            cnt   <= '0;
            mask  <= '0;
            stage <= '0;
            r_q   <= cfg_r_i;
          end
        end
        AG_RUN: begin
          if (last_bfly) begin
            cnt <= '0;
            if (last_stage) begin
              state  <= AG_IDLE;
              done_q <= 1'b1;
              stage  <= '0;
              mask   <= '0;
            end else begin
              state <= AG_HOLD;
              stage <= stage + RW'(1);
              mask  <= {2'b11, mask[AW-1:2]};
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        AG_HOLD: begin
          if (adv_i) state <= AG_RUN;
        end
        default: state <= AG_IDLE;
      endcase
    end
  end

  assign run_o   = (state == AG_RUN);
  assign stage_o = stage;
  assign cnt_o   = cnt;
  assign mask_o  = mask;
  assign r_o     = r_q;
  assign done_o  = done_q;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (run_o && stage_o == '0 && cnt_o == '0));

  // R3
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !last_bfly) |=> (run_o && $stable(stage_o) && cnt_o == $past(cnt_o) + CW'(1)));

  // R6
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AG_HOLD && !adv_i) |=> (state == AG_HOLD && $stable(stage_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state == AG_IDLE && stage_o == '0));

endmodule

// File: rtl/r4ag_lane.sv
module r4ag_lane
  import r4ag_pkg::*;
#(
  parameter int LANE  = 0,
  parameter int MAX_R = 5,
  parameter int AW    = 10,
  parameter int CW    = 8,
  parameter int SW    = 4
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] hi_a_i,
  input  logic [SW-1:0] pos_i,
  output logic [AW-1:0] lin_o,
  output logic [1:0]    bank_o,
  output logic [AW-3:0] addr_o
);

  // counter digits under hi_c move up one digit; the rest stay in place
  function automatic logic [AW-1:0] place_digit(input logic [CW-1:0] cnt,
                                                input logic [AW-1:0] hi_a,
                                                input logic [SW-1:0] pos,
                                                input logic [1:0]    dig);
    logic [CW-1:0] hi_c;
    logic [AW-1:0] up;
    logic [AW-1:0] lo;
    logic [AW-1:0] sw;
    hi_c = hi_a[AW-1:2];
    up   = {cnt & hi_c, 2'b00};
    lo   = {2'b00, cnt & ~hi_c};
    sw   = {{(AW-2){1'b0}}, dig} << pos;
    return up | lo | sw;
  endfunction

  function automatic logic [1:0] digit_bank(input logic [AW-1:0] a);
    logic [1:0] acc;
    acc = 2'b00;
    for (int i = 0; i < MAX_R; i++) acc = add2_mod4(acc, a[2*i +: 2]);
    return acc;
  endfunction

  always_comb begin
    lin_o  = place_digit(cnt_i, hi_a_i, pos_i, 2'(LANE));
    bank_o = digit_bank(lin_o);
    addr_o = lin_o[AW-1:2];
  end

endmodule

// File: rtl/r4_bank_agen.sv
module r4_bank_agen
  import r4ag_pkg::*;
#(
  parameter  int MAX_R = 5,
  localparam int RW    = $clog2(MAX_R + 1),
  localparam int AW    = 2 * MAX_R,
  localparam int MW    = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic [RW-1:0] cfg_r_i,
  output logic          valid_o,
  output logic [RW-1:0] stage_o,
  output logic          done_o,
  output logic [7:0]    bank_o,
  output logic [4*MW-1:0] addr_o
);

  localparam int CW = AW - 2;
  localparam int SW = $clog2(AW + 1);

  logic          run;
  logic [RW-1:0] stage;
  logic [CW-1:0] cnt;
  logic [AW-1:0] mask;
  logic [RW-1:0] r_q;
  logic [SW-1:0] align_sh;
  logic [SW-1:0] pos_sh;
  logic [AW-1:0] hi_a;
  logic [AW-1:0] lin [4];
  logic [1:0]    bank [4];

  r4ag_ctrl #(
    .MAX_R(MAX_R), .RW(RW), .AW(AW), .CW(CW), .SW(SW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .adv_i   (adv_i),
    .cfg_r_i (cfg_r_i),
    .run_o   (run),
    .stage_o (stage),
    .cnt_o   (cnt),
    .mask_o  (mask),
    .r_o     (r_q),
    .done_o  (done_o)
  );

  // align the mask to the r-digit field; the swept digit is r-p-1
  always_comb begin
    align_sh = SW'(2 * (MAX_R - int'(r_q)));
    pos_sh   = SW'(2 * (int'(r_q) - int'(stage) - 1));
    hi_a     = mask >> align_sh;
  end

  for (genvar j = 0; j < 4; j++) begin : g_lane
    r4ag_lane #(
      .LANE(j), .MAX_R(MAX_R), .AW(AW), .CW(CW), .SW(SW)
    ) u_lane (
      .cnt_i  (cnt),
      .hi_a_i (hi_a),
      .pos_i  (pos_sh),
      .lin_o  (lin[j]),
      .bank_o (bank[j]),
      .addr_o (addr_o[MW*j +: MW])
    );
    assign bank_o[2*j +: 2] = bank[j];
  end

  assign valid_o = run;
  assign stage_o = stage;

  // R4
  bank_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (bank[0] != bank[1] && bank[0] != bank[2] && bank[0] != bank[3] &&
                 bank[1] != bank[2] && bank[1] != bank[3] && bank[2] != bank[3]));

  // R8
  stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (stage_o < r_q));

  // R5
  lane_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (lin[0] != lin[3] && lin[1] != lin[2]));

endmodule

// File: tb/r4_bank_agen_tb.sv
module r4_bank_agen_tb;

  localparam int MAX_R = 5;
  localparam int RW    = $clog2(MAX_R + 1);
  localparam int MW    = 2 * MAX_R - 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic            adv_i = 1'b0;
  logic [RW-1:0]   cfg_r_i = '0;
  logic            valid_o;
  logic [RW-1:0]   stage_o;
  logic            done_o;
  logic [7:0]      bank_o;
  logic [4*MW-1:0] addr_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit wd_hit = 0;

  // reference model state: 0 idle, 1 run, 2 hold
  int m_state = 0;
  int m_r = 1;
  int m_p = 0;
  int m_c = 0;
  bit m_done = 0;
  bit seen [1024];
  int uniq = 0;
  bit inject = 0;

  always #4 clk = ~clk;

  r4_bank_agen #(.MAX_R(MAX_R)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i),
    .cfg_r_i(cfg_r_i), .valid_o(valid_o), .stage_o(stage_o),
    .done_o(done_o), .bank_o(bank_o), .addr_o(addr_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pow4(input int e);
    return 1 << (2 * e);
  endfunction

  function automatic int exp_lin(input int c, input int p, input int r, input int j);
    int pw;
    pw = pow4(r - p - 1);
    return (c / pw) * pw * 4 + j * pw + (c % pw);
  endfunction

  function automatic int dsum(input int a);
    int s = 0;
    int v = a;
    while (v > 0) begin
      s += v % 4;
      v /= 4;
    end
    return s % 4;
  endfunction

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_p = 0; m_c = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (m_state)
        0: if (start_i && cfg_r_i >= 1 && cfg_r_i <= MAX_R) begin
             m_r = int'(cfg_r_i); m_p = 0; m_c = 0; m_state = 1;
           end
        1: if (m_c == pow4(m_r - 1) - 1) begin
             m_c = 0;
             if (m_p == m_r - 1) begin
               m_state = 0; m_done = 1; m_p = 0;
             end else begin
               m_state = 2; m_p++;
             end
           end else m_c++;
        default: if (adv_i) m_state = 1;
      endcase
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(valid_o == (m_state == 1), (m_state == 2) ? "R6 valid in hold" : "R3 valid",
          int'(valid_o), int'(m_state == 1));
      chk(int'(stage_o) == m_p, "R8 stage", int'(stage_o), m_p);
      chk(done_o == m_done, "R7 done", int'(done_o), int'(m_done));
      if (m_state == 1) begin
        for (int j = 0; j < 4; j++) begin
          int a;
          int bk;
          int ad;
          int d0;
          a  = exp_lin(m_c, m_p, m_r, j);
          bk = int'(bank_o[2*j +: 2]);
          ad = int'(addr_o[MW*j +: MW]);
          chk(bk == dsum(a), "R4 bank", bk, dsum(a));
          chk(ad == a / 4, "R5 in-bank address", ad, a / 4);
          d0 = (((bk - dsum(ad)) % 4) + 4) % 4;
          chk(ad * 4 + d0 == a, "R3 lane operand mapped back", ad * 4 + d0, a);
          chk(!seen[a], "R3 address repeated in stage", a, -1);
          seen[a] = 1;
          uniq++;
        end
        for (int x = 0; x < 4; x++)
          for (int y = x + 1; y < 4; y++)
            chk(bank_o[2*x +: 2] != bank_o[2*y +: 2], "R4 distinct banks",
                int'(bank_o[2*x +: 2]), -1);
        if (m_c == pow4(m_r - 1) - 1) begin
          chk(uniq == pow4(m_r), "R3 stage coverage", uniq, pow4(m_r));
          uniq = 0;
          foreach (seen[k]) seen[k] = 0;
        end
      end
    end
  end

  task automatic run_fft(input int r, input int adv_delay);
    int hold_n = 0;
    int cyc = 0;
    @(negedge clk);
    start_i = 1'b1;
    cfg_r_i = RW'(r);
    @(negedge clk);
    start_i = 1'b0;
    // R2: first butterfly of stage 0
    chk(valid_o && stage_o == '0, "R2 start accepted", int'(valid_o), 1);
    while (m_state != 0) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      adv_i = 1'b0;
      if (m_state == 2) begin
        adv_i = (hold_n >= adv_delay);
        hold_n++;
      end else begin
        hold_n = 0;
        if (inject && (cyc % 5 == 0)) begin
          adv_i = 1'b1;
          start_i = 1'b1;
          cfg_r_i = RW'(2);
        end
      end
    end
    adv_i = 1'b0;
    start_i = 1'b0;
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    // R1
    chk(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    chk(stage_o == '0, "R1 reset stage", int'(stage_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: out-of-range r ignored
    start_i = 1'b1; cfg_r_i = '0;
    @(negedge clk);
    cfg_r_i = RW'(MAX_R + 1);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 bad r ignored", int'(valid_o), 0);
    run_fft(1, 0);
    chk(valid_o == 1'b0 && stage_o == '0, "R7 idle after r=1", int'(valid_o), 0);
    run_fft(2, 0);
    run_fft(3, 4);
    inject = 1;
    run_fft(3, 2);
    run_fft(2, 6);
    inject = 0;
    run_fft(MAX_R, 1);
    repeat (4) @(negedge clk);
    chk(valid_o == 1'b0, "R7 stays idle", int'(valid_o), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    if (wd_hit) chk(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule